// File: doc/BRIEF.md
# Dual-Phase Coarse Time Counter

This block keeps the coarse part of a timestamp for a time-to-digital converter. Two counters count reference clock periods. One counter advances on the rising edge of the reference clock and the other on the falling edge, so at any instant one of them is half a period away from its next change. When a hit arrives, external hit registers latch both counter words and the fine tap position, which is taken from a delay line that splits one clock period into equal taps. The block uses the fine position to choose the counter word that was stable at the hit. It then corrects that word so that every hit gets the same coarse count for the same reference period, whichever counter supplied it.

Each counter is split into 4-bit slices. The carry into each slice is formed in parallel as the AND of the all-ones terms of every lower slice, so no carry ripples from slice to slice. The next-state logic drives a synchronous reset into the flip-flop data inputs as zero. The falling-edge counter uses a copy of the reset that is registered on the rising edge. This keeps the two counters in step after reset is released. Both counters wrap modulo 2^WIDTH without any flag. The selected timestamp is registered and comes with a one-cycle valid strobe.

Top module: `dual_phase_coarse_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the rising-edge counter and `coarse_o` become 0 and `coarse_valid_o` goes low. Within two cycles the falling-edge counter also reads 0.
- R2: After reset is released, `cnt_rise_o` goes up by exactly one at each rising edge, carrying correctly across every 4-bit slice boundary. The first rising edge with `rst` low makes it 1.
- R3: `cnt_fall_o` goes up by one at each falling edge. In the first half of a period it reads one less than `cnt_rise_o`, and in the second half it reads the same value.
- R4: Both counters wrap from 2^WIDTH-1 to 0 with no flag. The corrected selection wraps in the same way, so a falling-edge word of 2^WIDTH-1 yields 0.
- R5: If `cap_fine_i` is below TAPS/2 (a hit in the first half period, where tap n means n·period/TAPS after the rising edge), the result is `cap_fall_i + 1` modulo 2^WIDTH.
- R6: If `cap_fine_i` is TAPS/2 or more, the result is `cap_rise_i` unchanged.
- R7: A rising edge that samples `cap_valid_i` high loads the result into `coarse_o` and drives `coarse_valid_o` high until the next edge.
- R8: A rising edge that samples `cap_valid_i` low leaves `coarse_o` unchanged and drives `coarse_valid_o` low, whatever the other capture inputs carry.
- R9: The counter word that is not selected has no effect on the result, even if it holds garbage. This covers a rising-edge word corrupted at tap 0 and a falling-edge word corrupted at tap TAPS/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| cnt_rise_o | output | WIDTH | Live rising-edge counter, sent to the hit registers |
| cnt_fall_o | output | WIDTH | Live falling-edge counter, sent to the hit registers |
| cap_valid_i | input | 1 | Captured hit is present for selection |
| cap_rise_i | input | WIDTH | Rising-edge counter word latched at the hit |
| cap_fall_i | input | WIDTH | Falling-edge counter word latched at the hit |
| cap_fine_i | input | $clog2(TAPS) | Fine tap position of the hit inside the period |
| coarse_valid_o | output | 1 | Strobe that marks a new timestamp |
| coarse_o | output | WIDTH | Corrected coarse timestamp |

## Verification
The bench sweeps hits across every tap, several times over. It emulates unstable capture by inverting the rising-edge word at tap 0 and the falling-edge word at tap TAPS/2. A design with the split point off by one tap, or with the selection reversed, would return the corrupted word. A missing +1 correction would report one period early for every first-half hit. Dedicated hits placed just after the counter wraps, and a count sweep longer than the 8-bit test width, catch a correction that does not wrap and a slice carry that is formed wrongly. The sweep also checks the half-period offset between the counters, which would break if the falling-edge counter came out of reset on the wrong edge.

// File: rtl/dpcc_pkg.sv
`timescale 1ps/1ps
package dpcc_pkg;
  typedef enum logic {
    SRC_RISE = 1'b0,
    SRC_FALL = 1'b1
  } dpcc_src_e;
endpackage

// File: rtl/cla_slice.sv
`timescale 1ps/1ps
// One increment slice: next value from the current bits and the slice carry-in,
// plus an all-ones term that feeds the look-ahead of the higher slices.
module cla_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] q,
  input  logic          cin,
  output logic [SW-1:0] q_next,
  output logic          all_ones
);
  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < SW; i++) begin
      q_next[i] = q[i] ^ c;
      c = c & q[i];
    end
  end

  assign all_ones = &q;
endmodule

// File: rtl/la_counter.sv
`timescale 1ps/1ps
// Free-running counter built from slices with parallel slice carries.
module la_counter #(
  parameter int WIDTH = 32,
  parameter int SLICE = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] q
);
  localparam int NSL = WIDTH / SLICE;

  logic [NSL-1:0]   prop;
  logic [NSL-1:0]   cin_v;
  logic [WIDTH-1:0] q_inc;
  logic [WIDTH-1:0] d;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    if (s == 0) begin : g_first
      assign cin_v[s] = 1'b1;
    end else begin : g_rest
      assign cin_v[s] = &prop[s-1:0];
    end
    cla_slice #(.SW(SLICE)) i_slice (
      .q        (q[s*SLICE +: SLICE]),
      .cin      (cin_v[s]),
      .q_next   (q_inc[s*SLICE +: SLICE]),
      .all_ones (prop[s])
    );
  end

  // reset enters through the data path
  assign d = rst ? '0 : q_inc;

  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/phase_select.sv
`timescale 1ps/1ps
// Picks the counter word that was stable at the hit and aligns it.
module phase_select
  import dpcc_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int TAPS   = 32,
  parameter int FINE_W = $clog2(TAPS)
) (
  input  logic [WIDTH-1:0]  rise_w,
  input  logic [WIDTH-1:0]  fall_w,
  input  logic [FINE_W-1:0] fine,
  output logic [WIDTH-1:0]  sel_w
);
  localparam int HALF = TAPS / 2;

  dpcc_src_e src;

  always_comb begin
    src = (fine < FINE_W'(HALF)) ? SRC_FALL : SRC_RISE;
    if (src == SRC_FALL) begin
      sel_w = fall_w + WIDTH'(1);
    end else begin
      sel_w = rise_w;
    end
  end
endmodule

// File: rtl/dual_phase_coarse_counter.sv
`timescale 1ps/1ps
module dual_phase_coarse_counter #(
  parameter int WIDTH  = 32,
  parameter int SLICE  = 4,
  parameter int TAPS   = 32,
  parameter int FINE_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WIDTH-1:0]  cnt_rise_o,
  output logic [WIDTH-1:0]  cnt_fall_o,
  input  logic              cap_valid_i,
  input  logic [WIDTH-1:0]  cap_rise_i,
  input  logic [WIDTH-1:0]  cap_fall_i,
  input  logic [FINE_W-1:0] cap_fine_i,
  output logic              coarse_valid_o,
  output logic [WIDTH-1:0]  coarse_o
);
  logic             clk_n;
  logic             rst_r;
  logic [WIDTH-1:0] sel_w;

  assign clk_n = ~clk;

  // reset copy latched on the rising edge for the falling-edge counter
  always_ff @(posedge clk) begin
    rst_r <= rst;
  end

  la_counter #(.WIDTH(WIDTH), .SLICE(SLICE)) i_cnt_rise (
    .clk (clk),
    .rst (rst),
    .q   (cnt_rise_o)
  );

  la_counter #(.WIDTH(WIDTH), .SLICE(SLICE)) i_cnt_fall (
    .clk (clk_n),
    .rst (rst_r),
    .q   (cnt_fall_o)
  );

  phase_select #(.WIDTH(WIDTH), .TAPS(TAPS), .FINE_W(FINE_W)) i_sel (
    .rise_w (cap_rise_i),
    .fall_w (cap_fall_i),
    .fine   (cap_fine_i),
    .sel_w  (sel_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_valid_o <= 1'b0;
      coarse_o       <= '0;
    end else begin
      coarse_valid_o <= cap_valid_i;
      if (cap_valid_i) begin
        coarse_o <= sel_w;
      end
    end
  end
endmodule

// File: rtl/dpcc_chk.sv
`timescale 1ps/1ps
module dpcc_chk #(
  parameter int WIDTH  = 32,
  parameter int TAPS   = 32,
  parameter int FINE_W = $clog2(TAPS)
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  cnt_rise_o,
  input logic [WIDTH-1:0]  cnt_fall_o,
  input logic              cap_valid_i,
  input logic [WIDTH-1:0]  cap_rise_i,
  input logic [WIDTH-1:0]  cap_fall_i,
  input logic [FINE_W-1:0] cap_fine_i,
  input logic              coarse_valid_o,
  input logic [WIDTH-1:0]  coarse_o
);
  localparam int HALF = TAPS / 2;

  logic [1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= 2'd0;
    else if (run != 2'd2) run <= run + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt_rise_o == '0 && !coarse_valid_o && coarse_o == '0));

  // R2
  rise_step_chk: assert property (@(posedge clk) disable iff (rst)
    run != 2'd0 |-> cnt_rise_o == WIDTH'($past(cnt_rise_o) + WIDTH'(1)));

  // R3
  phase_pair_chk: assert property (@(posedge clk) disable iff (rst)
    run == 2'd2 |-> cnt_fall_o == cnt_rise_o);

  // R5
  early_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_i && cap_fine_i < FINE_W'(HALF)) |=>
      coarse_o == WIDTH'($past(cap_fall_i) + WIDTH'(1)));

  // R6
  late_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_i && cap_fine_i >= FINE_W'(HALF)) |=> coarse_o == $past(cap_rise_i));

  // R7
  strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cap_valid_i |=> coarse_valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_valid_i |=> (!coarse_valid_o && $stable(coarse_o)));
endmodule

bind dual_phase_coarse_counter dpcc_chk #(
  .WIDTH(WIDTH), .TAPS(TAPS), .FINE_W(FINE_W)
) i_dpcc_chk (
  .clk            (clk),
  .rst            (rst),
  .cnt_rise_o     (cnt_rise_o),
  .cnt_fall_o     (cnt_fall_o),
  .cap_valid_i    (cap_valid_i),
  .cap_rise_i     (cap_rise_i),
  .cap_fall_i     (cap_fall_i),
  .cap_fine_i     (cap_fine_i),
  .coarse_valid_o (coarse_valid_o),
  .coarse_o       (coarse_o)
);

// File: tb/test_dual_phase_coarse_counter.sv
`timescale 1ps/1ps
module test_dual_phase_coarse_counter;
  localparam int CLK_PERIOD = 3200;
  localparam int W          = 8;
  localparam int TAPS       = 32;
  localparam int FW         = $clog2(TAPS);
  localparam int HALF       = TAPS / 2;
  localparam int TAP_PS     = CLK_PERIOD / TAPS;
  localparam int QTR        = CLK_PERIOD / 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  cnt_rise, cnt_fall;
  logic          cap_valid = 1'b0;
  logic [W-1:0]  cap_rise = '0;
  logic [W-1:0]  cap_fall = '0;
  logic [FW-1:0] cap_fine = '0;
  logic          coarse_valid;
  logic [W-1:0]  coarse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int unsigned ideal = 0;

  dual_phase_coarse_counter #(.WIDTH(W), .SLICE(4), .TAPS(TAPS)) i_dual_phase_coarse_counter (
    .clk            (clk),
    .rst            (rst),
    .cnt_rise_o     (cnt_rise),
    .cnt_fall_o     (cnt_fall),
    .cap_valid_i    (cap_valid),
    .cap_rise_i     (cap_rise),
    .cap_fall_i     (cap_fall),
    .cap_fine_i     (cap_fine),
    .coarse_valid_o (coarse_valid),
    .coarse_o       (coarse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal period count since reset release
  always @(posedge clk) begin
    if (rst) ideal <= 0;
    else     ideal <= ideal + 1;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hit(input int tap, input bit bad_rise, input bit bad_fall, input string req);
    logic [W-1:0] exp, cr, cf, held;
    @(posedge clk);
    #1;
    exp = W'(ideal);
    #(tap*TAP_PS + TAP_PS/2 - 1);
    cr = cnt_rise;
    cf = cnt_fall;
    if (bad_rise) cr = ~cr ^ W'(tap*37);
    if (bad_fall) cf = ~cf ^ W'(tap*53);
    @(negedge clk);
    cap_valid = 1'b1;
    cap_rise  = cr;
    cap_fall  = cf;
    cap_fine  = FW'(tap);
    @(posedge clk);
    #QTR;
    chk(req, coarse, exp);
    chk("R7", W'(coarse_valid), W'(1));
    held = coarse;
    cap_valid = 1'b0;
    cap_rise  = ~cr;
    cap_fall  = ~cf;
    cap_fine  = ~FW'(tap);
    @(posedge clk);
    #QTR;
    chk("R8", W'(coarse_valid), W'(0));
    chk("R8", coarse, held);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #QTR;
    chk("R1", cnt_rise, '0);
    chk("R1", cnt_fall, '0);
    chk("R1", W'(coarse_valid), W'(0));
    chk("R1", coarse, '0);
    rst = 1'b0;

    // counting, half-period offset and wrap
    repeat (300) begin
      @(posedge clk);
      #QTR;
      chk("R2", cnt_rise, W'(ideal));
      chk("R3", cnt_fall, W'(ideal - 1));
      if (W'(ideal) == '0) chk("R4", cnt_rise, '0);
      #(CLK_PERIOD/2);
      chk("R3", cnt_fall, W'(ideal));
    end

    // tap sweep with the edge-adjacent word corrupted
    for (int rep = 0; rep < 4; rep++) begin
      for (int tap = 0; tap < TAPS; tap++) begin
        hit(tap, tap == 0, tap == HALF, (tap < HALF) ? "R5" : "R6");
      end
    end

    // unselected word carries garbage
    hit(7, 1'b1, 1'b0, "R9");
    hit(HALF - 1, 1'b1, 1'b0, "R9");
    hit(25, 1'b0, 1'b1, "R9");
    hit(HALF, 1'b0, 1'b1, "R9");

    // hits right after the wrap
    do begin @(posedge clk); #1; end while (W'(ideal) != {W{1'b1}});
    hit(4, 1'b0, 1'b0, "R4");
    do begin @(posedge clk); #1; end while (W'(ideal) != {W{1'b1}});
    hit(20, 1'b0, 1'b0, "R4");

    // reset during operation
    @(posedge clk);
    #QTR;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #QTR;
    chk("R1", cnt_rise, '0);
    chk("R1", cnt_fall, '0);
    chk("R1", W'(coarse_valid), W'(0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule